// File: doc/BRIEF.md
# Register Redirection Table

This block turns a small list of programmable configuration entries into two sparse lookup tables. One table serves integer register numbers and the other serves floating-point register numbers. Each table has one slot per architectural register number. An entry names a table, a key (the register number as it appears in an instruction) and the attributes that key should carry:

- an element width code,
- a target register index,
- a vector flag,
- a packed (sub-word SIMD) flag.

A programmed slot reports itself as enabled.

Decode logic presents a table select and a register number on the lookup port. In the same cycle it receives the redirected index and the attributes. A register number whose slot holds no entry passes through unchanged and is treated as scalar.

The target index carries a bank extension. The bank is added above the register-number bits. Bank values at or beyond the legal count are rejected. Such a write raises a sticky error flag and leaves the stored entries unchanged.

Entries are kept in numbered positions, and the tables are derived from them. When two live entries name the same table and key, the higher-numbered entry supplies the slot. The order in which the entries were written does not matter.

Top module: `reg_redirect_table`

## Requirements
- R1: After reset every slot in both tables is disabled and `cfg_err` is 0. A lookup of any register number then returns `lk_hit`=0, `lk_vec`=0, `lk_pack`=0, `lk_elw`=0 and `lk_idx` equal to the zero-extended register number.
- R2: `cfg_type`=0 places an entry in the integer table, which is looked up with `lk_fp`=0. Any non-zero `cfg_type` value, including 2, places it in the floating-point table, which is looked up with `lk_fp`=1.
- R3: A lookup of a slot programmed by a live entry returns `lk_hit`=1 together with the entry's `cfg_elw`, `cfg_vec` and `cfg_pack`. It also returns `lk_idx` = `cfg_tgt` + (`cfg_bank` << 5). Every index reported on a hit lies in a legal bank.
- R4: A lookup of a slot holding no live entry returns the register number itself as `lk_idx`, with `lk_hit`=0 and `lk_vec`=0. This holds for register numbers 0 and 31.
- R5: When two live entries share the same table and key, the slot reflects the entry with the higher `cfg_sel` number. Rewriting the lower-numbered entry afterwards does not change the slot.
- R6: A write whose `cfg_bank` is not 0 (1 is reserved) changes no stored entry. The slot it names keeps its previous contents, and `cfg_err` reads 1 from the next cycle on.
- R7: `cfg_err` stays 1 through later legal writes and returns to 0 only on reset.
- R8: The lookup is combinational on stored state. A write becomes visible on the cycle after the clock edge that captures it, and a lookup in the write's own cycle still shows the old contents.
- R9: The integer and floating-point tables are independent. Programming a key in one table leaves the same key in the other table untouched.
- R10: Rewriting an entry with a new key moves it. The slot it previously fed becomes disabled unless another live entry still names that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_sel | input | 4 | Entry number written |
| cfg_type | input | 2 | Table select, 0 integer, otherwise floating-point |
| cfg_key | input | 5 | Instruction register number the entry keys on |
| cfg_elw | input | 2 | Element width code |
| cfg_tgt | input | 5 | Redirected register index within the bank |
| cfg_bank | input | 1 | Bank extension, only 0 legal |
| cfg_vec | input | 1 | Vector flag |
| cfg_pack | input | 1 | Packed (SIMD) flag |
| cfg_err | output | 1 | Sticky flag: a reserved bank value was written |
| lk_fp | input | 1 | Lookup table select, 1 floating-point |
| lk_reg | input | 5 | Lookup register number |
| lk_hit | output | 1 | Slot is enabled |
| lk_idx | output | 6 | Redirected or passed-through register index |
| lk_elw | output | 2 | Element width of the slot |
| lk_vec | output | 1 | Vector flag of the slot |
| lk_pack | output | 1 | Packed flag of the slot |

## Verification
The assertions check four properties on every cycle:

- a rejected bank write leaves the stored entries unchanged and raises the error flag,
- the flag never drops outside reset,
- an accepted write arms its entry,
- a miss passes the register number through as scalar while a hit always reports a legal bank.

Only the bench's scenarios can show the rest:

- the priority between entries that collide,
- the separation of the two tables,
- an entry moving to a new key,
- the exact one-cycle visibility of a write.

Each of these depends on a particular history of writes.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
   typedef enum logic {
      RRT_INT = 1'b0,
      RRT_FP  = 1'b1
   } rrt_tbl_e;

   localparam int RRT_N_TABLES = 2;
endpackage

// File: rtl/rrt_entry_store.sv
module rrt_entry_store
   import rrt_pkg::*;
#(
   parameter int N_ENT     = 16,
   parameter int TYPE_W    = 2,
   parameter int KEY_W     = 5,
   parameter int ELW_W     = 2,
   parameter int BANK_W    = 1,
   parameter int N_BANK_OK = 1,
   localparam int SEL_W    = $clog2(N_ENT),
   localparam int IDX_W    = KEY_W + BANK_W
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [SEL_W-1:0]              cfg_sel,
   input  logic [TYPE_W-1:0]             cfg_type,
   input  logic [KEY_W-1:0]              cfg_key,
   input  logic [ELW_W-1:0]              cfg_elw,
   input  logic [KEY_W-1:0]              cfg_tgt,
   input  logic [BANK_W-1:0]             cfg_bank,
   input  logic                          cfg_vec,
   input  logic                          cfg_pack,
   output logic [N_ENT-1:0]              ent_vld,
   output logic [N_ENT-1:0]              ent_tbl,
   output logic [N_ENT-1:0][KEY_W-1:0]   ent_key,
   output logic [N_ENT-1:0][ELW_W-1:0]   ent_elw,
   output logic [N_ENT-1:0][IDX_W-1:0]   ent_idx,
   output logic [N_ENT-1:0]              ent_vec,
   output logic [N_ENT-1:0]              ent_pack,
   output logic                          err
);
   logic             bank_ok;
   logic [N_ENT-1:0] sel_oh;
   logic [IDX_W-1:0] full_idx;

   assign bank_ok  = 32'(cfg_bank) < N_BANK_OK;
   assign sel_oh   = N_ENT'(1) << cfg_sel;
   assign full_idx = IDX_W'(cfg_tgt) + (IDX_W'(cfg_bank) << KEY_W);

   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_vld[e]  <= 1'b0;
            ent_tbl[e]  <= RRT_INT;
            ent_key[e]  <= '0;
            ent_elw[e]  <= '0;
            ent_idx[e]  <= '0;
            ent_vec[e]  <= 1'b0;
            ent_pack[e] <= 1'b0;
         end else if (cfg_we && bank_ok && sel_oh[e]) begin
            ent_vld[e]  <= 1'b1;
            ent_tbl[e]  <= (cfg_type != '0) ? RRT_FP : RRT_INT;
            ent_key[e]  <= cfg_key;
            ent_elw[e]  <= cfg_elw;
            ent_idx[e]  <= full_idx;
            ent_vec[e]  <= cfg_vec;
            ent_pack[e] <= cfg_pack;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                  err <= 1'b0;
      else if (cfg_we && !bank_ok) err <= 1'b1;
   end

   AST_RSVD_BANK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && (32'(cfg_bank) >= N_BANK_OK) |=> $stable(ent_vld) && $stable(ent_idx) && $stable(ent_key)); // R6
   AST_RSVD_BANK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && (32'(cfg_bank) >= N_BANK_OK) |=> err); // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err); // R7
   AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && (32'(cfg_bank) < N_BANK_OK) |=> (ent_vld & $past(sel_oh)) != '0); // R2
endmodule

// File: rtl/rrt_slot_build.sv
module rrt_slot_build
   import rrt_pkg::*;
#(
   parameter int N_ENT   = 16,
   parameter int KEY_W   = 5,
   parameter int ELW_W   = 2,
   parameter int IDX_W   = 6,
   localparam int NREG   = 2 ** KEY_W,
   localparam int N_SLOT = RRT_N_TABLES * NREG
)(
   input  logic [N_ENT-1:0]              ent_vld,
   input  logic [N_ENT-1:0]              ent_tbl,
   input  logic [N_ENT-1:0][KEY_W-1:0]   ent_key,
   input  logic [N_ENT-1:0][ELW_W-1:0]   ent_elw,
   input  logic [N_ENT-1:0][IDX_W-1:0]   ent_idx,
   input  logic [N_ENT-1:0]              ent_vec,
   input  logic [N_ENT-1:0]              ent_pack,
   output logic [N_SLOT-1:0]             slot_hit,
   output logic [N_SLOT-1:0][ELW_W-1:0]  slot_elw,
   output logic [N_SLOT-1:0][IDX_W-1:0]  slot_idx,
   output logic [N_SLOT-1:0]             slot_vec,
   output logic [N_SLOT-1:0]             slot_pack
);
   for (genvar t = 0; t < RRT_N_TABLES; t++) begin : g_tbl
      localparam rrt_tbl_e TBL = rrt_tbl_e'(t);
      for (genvar k = 0; k < NREG; k++) begin : g_key
         localparam int S = t * NREG + k;
         logic             h;
         logic [ELW_W-1:0] w;
         logic [IDX_W-1:0] x;
         logic             v;
         logic             p;
         // ascending scan: a later (higher) entry overrides an earlier match
         always_comb begin
            h = 1'b0;
            w = '0;
            x = '0;
            v = 1'b0;
            p = 1'b0;
            for (int e = 0; e < N_ENT; e++) begin
               if (ent_vld[e] && (ent_tbl[e] == TBL) && (ent_key[e] == KEY_W'(k))) begin
                  h = 1'b1;
                  w = ent_elw[e];
                  x = ent_idx[e];
                  v = ent_vec[e];
                  p = ent_pack[e];
               end
            end
         end
         assign slot_hit[S]  = h;
         assign slot_elw[S]  = w;
         assign slot_idx[S]  = x;
         assign slot_vec[S]  = v;
         assign slot_pack[S] = p;
      end
   end
endmodule

// File: rtl/rrt_lookup.sv
module rrt_lookup
   import rrt_pkg::*;
#(
   parameter int KEY_W   = 5,
   parameter int ELW_W   = 2,
   parameter int IDX_W   = 6,
   localparam int N_SLOT = RRT_N_TABLES * (2 ** KEY_W)
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_SLOT-1:0]             slot_hit,
   input  logic [N_SLOT-1:0][ELW_W-1:0]  slot_elw,
   input  logic [N_SLOT-1:0][IDX_W-1:0]  slot_idx,
   input  logic [N_SLOT-1:0]             slot_vec,
   input  logic [N_SLOT-1:0]             slot_pack,
   input  logic                          lk_fp,
   input  logic [KEY_W-1:0]              lk_reg,
   output logic                          lk_hit,
   output logic [IDX_W-1:0]              lk_idx,
   output logic [ELW_W-1:0]              lk_elw,
   output logic                          lk_vec,
   output logic                          lk_pack
);
   logic [KEY_W:0] s;
   assign s = {lk_fp, lk_reg};

   always_comb begin
      lk_hit = slot_hit[s];
      if (slot_hit[s]) begin
         lk_idx  = slot_idx[s];
         lk_elw  = slot_elw[s];
         lk_vec  = slot_vec[s];
         lk_pack = slot_pack[s];
      end else begin
         lk_idx  = IDX_W'(lk_reg);
         lk_elw  = '0;
         lk_vec  = 1'b0;
         lk_pack = 1'b0;
      end
   end

   AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_idx == IDX_W'(lk_reg)) && !lk_vec); // R4
endmodule

// File: rtl/reg_redirect_table.sv
module reg_redirect_table
   import rrt_pkg::*;
#(
   parameter int N_ENT     = 16,
   parameter int NREG      = 32,
   parameter int TYPE_W    = 2,
   parameter int ELW_W     = 2,
   parameter int BANK_W    = 1,
   parameter int N_BANK_OK = 1,
   localparam int KEY_W    = $clog2(NREG),
   localparam int SEL_W    = $clog2(N_ENT),
   localparam int IDX_W    = KEY_W + BANK_W,
   localparam int N_SLOT   = RRT_N_TABLES * NREG
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [SEL_W-1:0]   cfg_sel,
   input  logic [TYPE_W-1:0]  cfg_type,
   input  logic [KEY_W-1:0]   cfg_key,
   input  logic [ELW_W-1:0]   cfg_elw,
   input  logic [KEY_W-1:0]   cfg_tgt,
   input  logic [BANK_W-1:0]  cfg_bank,
   input  logic               cfg_vec,
   input  logic               cfg_pack,
   output logic               cfg_err,
   input  logic               lk_fp,
   input  logic [KEY_W-1:0]   lk_reg,
   output logic               lk_hit,
   output logic [IDX_W-1:0]   lk_idx,
   output logic [ELW_W-1:0]   lk_elw,
   output logic               lk_vec,
   output logic               lk_pack
);
   if (NREG < 2 || NREG != 2 ** KEY_W) begin : g_chk_nreg
      $error("NREG must be a power of two, at least 2");
   end
   if (N_ENT < 2 || N_ENT != 2 ** SEL_W) begin : g_chk_nent
      $error("N_ENT must be a power of two, at least 2");
   end
   if (N_BANK_OK < 1 || N_BANK_OK > 2 ** BANK_W) begin : g_chk_bank
      $error("N_BANK_OK must lie in 1 .. 2**BANK_W");
   end
   if (TYPE_W < 1 || ELW_W < 1) begin : g_chk_fields
      $error("field widths must be positive");
   end

   logic [N_ENT-1:0]             ent_vld;
   logic [N_ENT-1:0]             ent_tbl;
   logic [N_ENT-1:0][KEY_W-1:0]  ent_key;
   logic [N_ENT-1:0][ELW_W-1:0]  ent_elw;
   logic [N_ENT-1:0][IDX_W-1:0]  ent_idx;
   logic [N_ENT-1:0]             ent_vec;
   logic [N_ENT-1:0]             ent_pack;

   logic [N_SLOT-1:0]             slot_hit;
   logic [N_SLOT-1:0][ELW_W-1:0]  slot_elw;
   logic [N_SLOT-1:0][IDX_W-1:0]  slot_idx;
   logic [N_SLOT-1:0]             slot_vec;
   logic [N_SLOT-1:0]             slot_pack;

   rrt_entry_store #(
      .N_ENT(N_ENT), .TYPE_W(TYPE_W), .KEY_W(KEY_W), .ELW_W(ELW_W),
      .BANK_W(BANK_W), .N_BANK_OK(N_BANK_OK)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_type(cfg_type), .cfg_key(cfg_key), .cfg_elw(cfg_elw),
      .cfg_tgt(cfg_tgt), .cfg_bank(cfg_bank), .cfg_vec(cfg_vec),
      .cfg_pack(cfg_pack), .ent_vld(ent_vld), .ent_tbl(ent_tbl),
      .ent_key(ent_key), .ent_elw(ent_elw), .ent_idx(ent_idx),
      .ent_vec(ent_vec), .ent_pack(ent_pack), .err(cfg_err)
   );

   rrt_slot_build #(
      .N_ENT(N_ENT), .KEY_W(KEY_W), .ELW_W(ELW_W), .IDX_W(IDX_W)
   ) u_build (
      .ent_vld(ent_vld), .ent_tbl(ent_tbl), .ent_key(ent_key),
      .ent_elw(ent_elw), .ent_idx(ent_idx), .ent_vec(ent_vec),
      .ent_pack(ent_pack), .slot_hit(slot_hit), .slot_elw(slot_elw),
      .slot_idx(slot_idx), .slot_vec(slot_vec), .slot_pack(slot_pack)
   );

   rrt_lookup #(
      .KEY_W(KEY_W), .ELW_W(ELW_W), .IDX_W(IDX_W)
   ) u_look (
      .clk(clk), .rst_n(rst_n), .slot_hit(slot_hit), .slot_elw(slot_elw),
      .slot_idx(slot_idx), .slot_vec(slot_vec), .slot_pack(slot_pack),
      .lk_fp(lk_fp), .lk_reg(lk_reg), .lk_hit(lk_hit), .lk_idx(lk_idx),
      .lk_elw(lk_elw), .lk_vec(lk_vec), .lk_pack(lk_pack)
   );

   AST_HIT_LEGAL_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> int'(lk_idx >> KEY_W) < N_BANK_OK); // R3
endmodule

// File: tb/tb_reg_redirect_table.sv
`timescale 1ns/1ps
module tb_reg_redirect_table;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [3:0] cfg_sel = '0;
   logic [1:0] cfg_type = '0;
   logic [4:0] cfg_key = '0;
   logic [1:0] cfg_elw = '0;
   logic [4:0] cfg_tgt = '0;
   logic [0:0] cfg_bank = '0;
   logic       cfg_vec = 1'b0;
   logic       cfg_pack = 1'b0;
   logic       cfg_err;
   logic       lk_fp = 1'b0;
   logic [4:0] lk_reg = '0;
   logic       lk_hit;
   logic [5:0] lk_idx;
   logic [1:0] lk_elw;
   logic       lk_vec;
   logic       lk_pack;

   always #2.5 clk = ~clk;

   reg_redirect_table dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_type(cfg_type), .cfg_key(cfg_key), .cfg_elw(cfg_elw),
      .cfg_tgt(cfg_tgt), .cfg_bank(cfg_bank), .cfg_vec(cfg_vec),
      .cfg_pack(cfg_pack), .cfg_err(cfg_err), .lk_fp(lk_fp),
      .lk_reg(lk_reg), .lk_hit(lk_hit), .lk_idx(lk_idx),
      .lk_elw(lk_elw), .lk_vec(lk_vec), .lk_pack(lk_pack)
   );

   typedef struct {
      logic       hit;
      logic [5:0] idx;
      logic [1:0] elw;
      logic       vec;
      logic       pack;
      logic       err;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   task automatic drive_write(input logic [3:0] sel, input logic [1:0] typ,
                              input logic [4:0] key, input logic [1:0] elw,
                              input logic [4:0] tgt, input logic bank,
                              input logic vec, input logic pack);
      cfg_we   = 1'b1;
      cfg_sel  = sel;
      cfg_type = typ;
      cfg_key  = key;
      cfg_elw  = elw;
      cfg_tgt  = tgt;
      cfg_bank = bank;
      cfg_vec  = vec;
      cfg_pack = pack;
   endtask

   task automatic wr(input logic [3:0] sel, input logic [1:0] typ,
                     input logic [4:0] key, input logic [1:0] elw,
                     input logic [4:0] tgt, input logic bank,
                     input logic vec, input logic pack);
      @(negedge clk);
      drive_write(sel, typ, key, elw, tgt, bank, vec, pack);
   endtask

   task automatic push_look(input logic fp, input logic [4:0] r,
                            input logic hit, input logic [5:0] idx,
                            input logic [1:0] elw, input logic vec,
                            input logic pack, input logic err, input string tag);
      exp_t it;
      lk_fp  = fp;
      lk_reg = r;
      it.hit = hit; it.idx = idx; it.elw = elw; it.vec = vec;
      it.pack = pack; it.err = err; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic look(input logic fp, input logic [4:0] r,
                       input logic hit, input logic [5:0] idx,
                       input logic [1:0] elw, input logic vec,
                       input logic pack, input logic err, input string tag);
      @(negedge clk);
      cfg_we = 1'b0;
      push_look(fp, r, hit, idx, elw, vec, pack, err, tag);
   endtask

   // monitor: compares outputs 1 ns after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (lk_hit !== e.hit || lk_idx !== e.idx || lk_elw !== e.elw ||
                lk_vec !== e.vec || lk_pack !== e.pack || cfg_err !== e.err) begin
               n_fail++;
               $display("FAIL %s: got hit=%0b idx=%0d elw=%0d vec=%0b pack=%0b err=%0b exp hit=%0b idx=%0d elw=%0d vec=%0b pack=%0b err=%0b",
                        e.tag, lk_hit, lk_idx, lk_elw, lk_vec, lk_pack, cfg_err,
                        e.hit, e.idx, e.elw, e.vec, e.pack, e.err);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got no completion exp completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: empty after reset
      look(1'b0, 5'd7,  1'b0, 6'd7,  2'd0, 1'b0, 1'b0, 1'b0, "R1 int 7 after reset");
      look(1'b1, 5'd31, 1'b0, 6'd31, 2'd0, 1'b0, 1'b0, 1'b0, "R1 fp 31 after reset");
      // R4: passthrough boundaries
      look(1'b0, 5'd0,  1'b0, 6'd0,  2'd0, 1'b0, 1'b0, 1'b0, "R4 int 0 miss");
      look(1'b0, 5'd31, 1'b0, 6'd31, 2'd0, 1'b0, 1'b0, 1'b0, "R4 int 31 miss");
      // R8: write and lookup in the same cycle shows old contents
      @(negedge clk);
      drive_write(4'd3, 2'd0, 5'd5, 2'd2, 5'd20, 1'b0, 1'b1, 1'b0);
      push_look(1'b0, 5'd5, 1'b0, 6'd5, 2'd0, 1'b0, 1'b0, 1'b0, "R8 same-cycle lookup");
      look(1'b0, 5'd5, 1'b1, 6'd20, 2'd2, 1'b1, 1'b0, 1'b0, "R3 int 5 hit next cycle");
      look(1'b1, 5'd5, 1'b0, 6'd5,  2'd0, 1'b0, 1'b0, 1'b0, "R9 fp 5 untouched");
      // R2: type value 2 selects the floating-point table
      wr(4'd4, 2'd2, 5'd5, 2'd1, 5'd9, 1'b0, 1'b0, 1'b1);
      look(1'b1, 5'd5, 1'b1, 6'd9,  2'd1, 1'b0, 1'b1, 1'b0, "R2 fp 5 via type 2");
      look(1'b0, 5'd5, 1'b1, 6'd20, 2'd2, 1'b1, 1'b0, 1'b0, "R9 int 5 kept");
      // R5: higher entry wins regardless of write order
      wr(4'd10, 2'd0, 5'd5, 2'd3, 5'd28, 1'b0, 1'b1, 1'b1);
      look(1'b0, 5'd5, 1'b1, 6'd28, 2'd3, 1'b1, 1'b1, 1'b0, "R5 entry 10 over 3");
      wr(4'd3, 2'd0, 5'd5, 2'd0, 5'd1, 1'b0, 1'b0, 1'b0);
      look(1'b0, 5'd5, 1'b1, 6'd28, 2'd3, 1'b1, 1'b1, 1'b0, "R5 rewrite of 3 loses");
      // R6: reserved bank rejected
      wr(4'd10, 2'd0, 5'd5, 2'd0, 5'd2, 1'b1, 1'b0, 1'b0);
      look(1'b0, 5'd5, 1'b1, 6'd28, 2'd3, 1'b1, 1'b1, 1'b1, "R6 bank 1 rejected");
      // R10: entry moves to a new key
      wr(4'd4, 2'd0, 5'd12, 2'd0, 5'd15, 1'b0, 1'b0, 1'b0);
      look(1'b1, 5'd5,  1'b0, 6'd5,  2'd0, 1'b0, 1'b0, 1'b1, "R10 fp 5 freed");
      look(1'b0, 5'd12, 1'b1, 6'd15, 2'd0, 1'b0, 1'b0, 1'b1, "R10 int 12 gained");
      // R7: error sticks through legal writes, clears on reset
      wr(4'd0, 2'd1, 5'd31, 2'd1, 5'd31, 1'b0, 1'b1, 1'b0);
      look(1'b1, 5'd31, 1'b1, 6'd31, 2'd1, 1'b1, 1'b0, 1'b1, "R7 err sticky after legal write");
      @(negedge clk);
      cfg_we = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      look(1'b0, 5'd5,  1'b0, 6'd5,  2'd0, 1'b0, 1'b0, 1'b0, "R7 reset clears err, R1 empty");
      look(1'b1, 5'd31, 1'b0, 6'd31, 2'd0, 1'b0, 1'b0, 1'b0, "R1 fp 31 empty again");
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule